// File: doc/BRIEF.md
# Card Slot Rail Mode Controller

This block decides, every clock, the state of three supply rails feeding a removable card: an auxiliary rail, a 3.3 V main rail and a 1.5 V main rail. For each rail it drives a pass-switch enable and an output-discharge enable. A rail is either connected, pulled to ground, or left floating. The block also produces a filtered, active-low overcurrent status.

Its inputs are all digital. They are:
- supply-good flags, already qualified by undervoltage lockout upstream;
- active-low shutdown and standby requests;
- two active-low card detects;
- per-rail overcurrent and thermal fault flags.

The analog switching, current limiting and voltage sensing live outside the block.

Standby has two meanings:
- If standby arrives while the card is already powered, the auxiliary rail stays on.
- If standby is already active when the card appears, or when standby is raised while the main supplies are missing, everything stays off and floating.

A registered tracker remembers which of the two cases applies.

Top module: `slot_pwr_ctrl`

## Requirements
- R1: The card counts as present when either `det_a_ni` or `det_b_ni` is low. It is absent only when both are high.
- R2: In every rail bus, bit 0 is the auxiliary rail, bit 1 the 3.3 V rail and bit 2 the 1.5 V rail. While `aux_ok_i` is low, `sw_en_o` and `dis_en_o` are both 3'b000. This overrides every other input.
- R3: With aux present and `shdn_ni` low, `sw_en_o` = 3'b000 and `dis_en_o` = 3'b111, whatever the card, standby and thermal state.
- R4: With aux present, shutdown inactive and any bit of `therm_i` high, `sw_en_o` and `dis_en_o` are both 3'b000.
- R5: With no card (and R2–R4 not applying), an inactive standby gives `sw_en_o` = 3'b000 and `dis_en_o` = 3'b111. An active standby gives all zeros.
- R6: Standby can be raised while the card is present and both main supplies are good. From then on, as long as standby stays active and the card stays in, the result is `sw_en_o` = 3'b001 and `dis_en_o` = 3'b000. This holds even if a main supply is later lost.
- R7: In the following cases, both buses are 3'b000 until standby is released:
  - standby is raised while the card is absent or a main supply is missing;
  - the card is removed while standby is active.
- R8: With the card present and standby inactive, loss of either `v33_ok_i` or `v15_ok_i` turns both main switches off. The auxiliary switch stays on: `sw_en_o` = 3'b001, `dis_en_o` = 3'b000.
- R9: With card present, all supplies good and shutdown, standby and thermal inactive, `sw_en_o` = 3'b111 and `dis_en_o` = 3'b000. No rail ever has its switch and its discharge enabled together.
- R10: Let N be `DEGLITCH_CYC`. `oc_no` goes low only after the OR of `oc_i` has been high at N consecutive clock edges. It returns high only after N consecutive low edges. Shorter excursions leave `oc_no` unchanged.
- R11: The outputs are registered: each reflects the inputs sampled at the preceding rising edge. During reset `sw_en_o` = 3'b000, `dis_en_o` = 3'b000 and `oc_no` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aux_ok_i | input | 1 | Auxiliary supply good |
| v33_ok_i | input | 1 | 3.3 V supply good |
| v15_ok_i | input | 1 | 1.5 V supply good |
| shdn_ni | input | 1 | Shutdown request, active low |
| stby_ni | input | 1 | Standby request, active low |
| det_a_ni | input | 1 | Card detect A, active low |
| det_b_ni | input | 1 | Card detect B, active low |
| oc_i | input | 3 | Per-rail overcurrent flags |
| therm_i | input | 3 | Per-rail thermal fault flags |
| sw_en_o | output | 3 | Pass-switch enables |
| dis_en_o | output | 3 | Discharge pull-down enables |
| oc_no | output | 1 | Filtered overcurrent status, active low |

## Verification
The bench builds the block with `DEGLITCH_CYC` set to 8 instead of a real 20 ms count. This lets it hold the fault input for exactly N-1 and exactly N cycles in each direction within a short run, and apply single-cycle glitches against both filtered states. The rail outputs are tested with the default-independent decode. A biased random stream toggles standby, the detects and the supplies against a bench model of the early/late standby memory. Directed sequences cover:
- standby raised before and after insertion;
- main supply loss under late standby;
- card removal with standby held.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
  localparam int unsigned NUM_RAILS = 3;
  localparam int unsigned IDX_AUX   = 0;

  typedef struct packed {
    logic [NUM_RAILS-1:0] sw;
    logic [NUM_RAILS-1:0] dis;
  } rail_cmd_t;
endpackage

// File: rtl/slot_stby_track.sv
module slot_stby_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_act_i,
  input  logic card_i,
  input  logic mains_i,
  output logic early_o
);
  logic early_q, prev_q, early_d;

  // early = standby predates card or main supplies; late standby is remembered while held
  always_comb begin
    if (!stby_act_i)   early_d = 1'b0;
    else if (!card_i)  early_d = 1'b1;
    else if (!prev_q)  early_d = !mains_i;
    else               early_d = early_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      early_q <= early_d;
      prev_q  <= stby_act_i;
    end
  end

  assign early_o = early_d;

  // R7
  stby_release_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_act_i |=> !early_q);
  // R7
  stby_nocard_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_act_i && !card_i) |=> early_q);
endmodule

// File: rtl/slot_rail_mode.sv
module slot_rail_mode
  import slot_pwr_pkg::*;
(
  input  logic      aux_ok_i,
  input  logic      shdn_act_i,
  input  logic      therm_any_i,
  input  logic      card_i,
  input  logic      stby_act_i,
  input  logic      early_i,
  input  logic      mains_i,
  output rail_cmd_t cmd_o
);
  logic live, all_on, aux_only, discharge;

  assign live      = aux_ok_i && !shdn_act_i && !therm_any_i;
  assign all_on    = live && card_i && !stby_act_i && mains_i;
  assign aux_only  = live && card_i &&
                     ((stby_act_i && !early_i) || (!stby_act_i && !mains_i));
  assign discharge = aux_ok_i &&
                     (shdn_act_i || (!therm_any_i && !card_i && !stby_act_i));

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    if (r == IDX_AUX) begin : g_aux
      assign cmd_o.sw[r] = all_on || aux_only;
    end else begin : g_main
      assign cmd_o.sw[r] = all_on;
    end
    assign cmd_o.dis[r] = discharge;
  end
endmodule

// File: rtl/slot_oc_filter.sv
module slot_oc_filter #(
  parameter int unsigned CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CNT_W = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC - 1);

  logic             flt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (raw_i == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      flt_q <= raw_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = flt_q;

  // R10
  oc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == flt_q) |=> $stable(flt_q));
  // R10
  oc_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/slot_pwr_ctrl.sv
module slot_pwr_ctrl
  import slot_pwr_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC = 20000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 aux_ok_i,
  input  logic                 v33_ok_i,
  input  logic                 v15_ok_i,
  input  logic                 shdn_ni,
  input  logic                 stby_ni,
  input  logic                 det_a_ni,
  input  logic                 det_b_ni,
  input  logic [NUM_RAILS-1:0] oc_i,
  input  logic [NUM_RAILS-1:0] therm_i,
  output logic [NUM_RAILS-1:0] sw_en_o,
  output logic [NUM_RAILS-1:0] dis_en_o,
  output logic                 oc_no
);
  logic      card, mains, stby_act, early, oc_flt;
  rail_cmd_t cmd;
  logic [NUM_RAILS-1:0] sw_q, dis_q;

  assign card     = !(det_a_ni && det_b_ni);
  assign mains    = v33_ok_i && v15_ok_i;
  assign stby_act = !stby_ni;

  slot_stby_track u_stby (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stby_act_i (stby_act),
    .card_i     (card),
    .mains_i    (mains),
    .early_o    (early)
  );

  slot_rail_mode u_mode (
    .aux_ok_i    (aux_ok_i),
    .shdn_act_i  (!shdn_ni),
    .therm_any_i (|therm_i),
    .card_i      (card),
    .stby_act_i  (stby_act),
    .early_i     (early),
    .mains_i     (mains),
    .cmd_o       (cmd)
  );

  slot_oc_filter #(.CYC(DEGLITCH_CYC)) u_oc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (|oc_i),
    .flt_o  (oc_flt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      dis_q <= '0;
    end else begin
      sw_q  <= cmd.sw;
      dis_q <= cmd.dis;
    end
  end

  assign sw_en_o  = sw_q;
  assign dis_en_o = dis_q;
  assign oc_no    = !oc_flt;

  // R2
  aux_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_ok_i |=> (sw_en_o == '0 && dis_en_o == '0));
  // R3
  shdn_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_ok_i && !shdn_ni) |=> (sw_en_o == '0 && dis_en_o == '1));
  // R4
  therm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_ok_i && shdn_ni && (|therm_i)) |=> (sw_en_o == '0 && dis_en_o == '0));
  // R9
  sw_dis_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o & dis_en_o) == '0);
  // R8
  main_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(v33_ok_i && v15_ok_i) |=> (sw_en_o[2:1] == 2'b00));
endmodule

// File: tb/slot_pwr_ctrl_tb.sv
module slot_pwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic aux_ok = 1, v33_ok = 1, v15_ok = 1, shdn_n = 1, stby_n = 1;
  logic det_a = 1, det_b = 1;
  logic [2:0] oc = '0, therm = '0;
  logic [2:0] sw_en, dis_en;
  logic oc_n;

  int total = 0, bad = 0;
  bit m_early = 0, m_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pwr_ctrl #(.DEGLITCH_CYC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .aux_ok_i(aux_ok), .v33_ok_i(v33_ok),
    .v15_ok_i(v15_ok), .shdn_ni(shdn_n), .stby_ni(stby_n), .det_a_ni(det_a),
    .det_b_ni(det_b), .oc_i(oc), .therm_i(therm), .sw_en_o(sw_en),
    .dis_en_o(dis_en), .oc_no(oc_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model(input bit e, output logic [2:0] s, output logic [2:0] d,
                                output string tag);
    bit card  = !(det_a && det_b);
    bit mains = v33_ok && v15_ok;
    bit sa    = !stby_n;
    s = 3'b000; d = 3'b000;
    if (!aux_ok)            tag = "R2";
    else if (!shdn_n)       begin d = 3'b111; tag = "R3"; end
    else if (|therm)        tag = "R4";
    else if (!card)         begin d = sa ? 3'b000 : 3'b111; tag = "R5"; end
    else if (sa && e)       tag = "R7";
    else if (sa)            begin s = 3'b001; tag = "R6"; end
    else if (!mains)        begin s = 3'b001; tag = "R8"; end
    else                    begin s = 3'b111; tag = "R9"; end
  endfunction

  function automatic bit next_early();
    bit card = !(det_a && det_b);
    if (stby_n)       return 1'b0;
    else if (!card)   return 1'b1;
    else if (!m_prev) return !(v33_ok && v15_ok);
    else              return m_early;
  endfunction

  task automatic step(input string tag_ovr = "");
    logic [2:0] es, ed;
    string tag;
    bit e = next_early();
    model(e, es, ed, tag);
    if (tag_ovr != "") tag = tag_ovr;
    m_early = e;
    m_prev  = !stby_n;
    @(posedge clk); @(negedge clk);
    chk({sw_en, dis_en} == {es, ed}, tag, {sw_en, dis_en}, {es, ed});
  endtask

  task automatic oc_check(input logic exp, input string tag);
    chk(oc_n == exp, tag, {5'b0, oc_n}, {5'b0, exp});
  endtask

  task automatic clk_n(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c));
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk({sw_en, dis_en, oc_n} == 7'b0000001 ? 1'b1 : 1'b0, "R11",
        {sw_en, dis_en}, 6'b0);
    rst_ni = 1'b1;

    // R5 no card, standby inactive
    step();
    // R1 single detects
    det_a = 0; det_b = 1; step("R1");
    det_a = 1; det_b = 0; step("R1");
    // R11 one-cycle latency: input change not yet visible mid-cycle
    det_b = 1; #1;
    chk(sw_en == 3'b111, "R11", {sw_en, dis_en}, {3'b111, 3'b000});
    step();
    det_a = 0;      step(); // R9
    stby_n = 0;     step(); // R6 late standby
    v15_ok = 0;     step(); // R6 persists after supply loss
    stby_n = 1;     step(); // R8
    v15_ok = 1; v33_ok = 0; step(); // R8 other rail
    v33_ok = 1;     step(); // R9
    // R7 card removal while standby held, then reinsertion
    stby_n = 0;     step();
    det_a = 1;      step();
    det_a = 0;      step();
    stby_n = 1;     step();
    // R7 standby raised with a main supply missing
    v33_ok = 0; stby_n = 0; step();
    v33_ok = 1;     step();
    stby_n = 1;     step();
    // R3, R4, R2 overrides
    shdn_n = 0; therm = 3'b010; step();
    shdn_n = 1;     step();
    therm = 3'b000; aux_ok = 0; step();
    aux_ok = 1;     step();

    // R10 deglitch
    oc = 3'b010; clk_n(N - 1); oc_check(1'b1, "R10");
    oc = 3'b000; clk_n(2);     oc_check(1'b1, "R10");
    oc = 3'b100; clk_n(N - 1); oc_check(1'b1, "R10");
    clk_n(1);                  oc_check(1'b0, "R10");
    oc = 3'b000; clk_n(1);     oc_check(1'b0, "R10");
    oc = 3'b001; clk_n(1);     oc_check(1'b0, "R10");
    oc = 3'b000; clk_n(N - 1); oc_check(1'b0, "R10");
    clk_n(1);                  oc_check(1'b1, "R10");

    // random stream on rail decode
    for (int i = 0; i < 3000; i++) begin
      aux_ok = ($urandom_range(0, 19) != 0);
      shdn_n = ($urandom_range(0, 14) != 0);
      therm  = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      if ($urandom_range(0, 3) == 0) stby_n = ~stby_n;
      if ($urandom_range(0, 5) == 0) det_a = ~det_a;
      if ($urandom_range(0, 7) == 0) det_b = ~det_b;
      if ($urandom_range(0, 4) == 0) v33_ok = ~v33_ok;
      if ($urandom_range(0, 4) == 0) v15_ok = ~v15_ok;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule